// File: doc/BRIEF.md
# Round-Robin Request/Grant Bus Arbiter

This block decides which of several masters on a shared parallel bus may start the next transaction. Each master drives its own active-low request line and receives its own active-low grant line. The arbiter also watches the two active-low bus-control lines, the transaction framing line and the initiator-ready line, so that it knows when the bus is quiet. It issues at most one grant at a time. It picks among requesters by a rotating priority, so no master waits forever.

A master that sees its grant asserted on a clock edge while the bus is quiet starts driving the bus after that edge. The arbiter issues grants only from a state with no grant outstanding. When any other master is requesting, it withdraws the current grant on the next clock. This places one empty clock between any two different grantees. When the bus is quiet and no master holds a grant, the arbiter grants on the clock after it samples a request. If the bus is busy, the grant waits until the bus goes quiet. With many masters, several other masters may each complete a transaction before a given requester is served.

Top module: `pci_arbiter`

## Requirements
- R1: At no time is more than one bit of `gnt_n` low.
- R2: After any clock edge at which `rst` is high, every bit of `gnt_n` is high. The rotation pointer points at the highest-numbered master, so master 0 has first priority.
- R3: Suppose no grant is outstanding, `frame_n` and `irdy_n` are both high, and at least one `req_n` bit is low at a clock edge. Then exactly one grant is low after that edge, and it belongs to a master that was requesting.
- R4: If no grant is outstanding and `frame_n` or `irdy_n` is low at a clock edge, then no grant is low after that edge.
- R5: A new grant goes to the first requesting master found by searching upward from the index after the most recent grantee, wrapping from the highest index to 0.
- R6: After a clock with a grant to master i, the next clock has either the same grant to master i or no grant at all.
- R7: If the master holding the grant has its `req_n` bit high at a clock edge, its grant is removed after that edge.
- R8: If any master other than the holder has its `req_n` bit low at a clock edge, the holder's grant is removed after that edge, whether or not the bus is busy.
- R9: While the holder keeps its `req_n` bit low and no other master requests, its grant stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | NUM_MASTERS | Active-low request, one bit per master |
| frame_n | input | 1 | Active-low transaction framing line of the shared bus |
| irdy_n | input | 1 | Active-low initiator-ready line of the shared bus |
| gnt_n | output | NUM_MASTERS | Active-low grant, one bit per master, registered |

## Verification
The bench builds the arbiter with four masters. This is the smallest count at which the rotating pointer wraps past several requesters, and at which one master must watch three others complete in turn before it is served. Directed sequences cover a simultaneous request from two masters, a grant held back by the framing line and by the ready line, a request withdrawn before use, and a full rotation with every master requesting. A long stretch of random requests and bus activity then compares every clock against a behavioural model.

// File: rtl/pciarb_pkg.sv
package pciarb_pkg;

    // Decision taken by the grant controller on a clock edge
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_HOLD  = 2'd1,
        ACT_DROP  = 2'd2,
        ACT_ISSUE = 2'd3
    } arb_act_e;

    // Bus is quiet when neither framing nor initiator-ready is driven low
    function automatic logic bus_quiet(input logic frame_n, input logic irdy_n);
        return frame_n & irdy_n;
    endfunction

    // Index width for a master count (at least one bit)
    function automatic int idx_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pciarb_idle_det.sv
module pciarb_idle_det
    import pciarb_pkg::*;
(
    input  logic frame_n,
    input  logic irdy_n,
    output logic bus_idle
);

    always_comb begin
        bus_idle = bus_quiet(frame_n, irdy_n);
    end

endmodule

// File: rtl/pciarb_rr_pick.sv
module pciarb_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          found,
    output logic [IW-1:0] win
);

    logic [IW-1:0] cand [N];
    logic [N-1:0]  rot;

    // Candidate k is the master (last + 1 + k) mod N
    for (genvar k = 0; k < N; k++) begin : g_rot
        logic [IW:0] sum;
        always_comb begin
            sum = {1'b0, last} + (IW+1)'(k + 1);
            if (sum >= (IW+1)'(N)) begin
                sum = sum - (IW+1)'(N);
            end
        end
        assign cand[k] = sum[IW-1:0];
        assign rot[k]  = req[cand[k]];
    end

    // First requester in rotated order wins
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int k = 0; k < N; k++) begin
            if (!found && rot[k]) begin
                found = 1'b1;
                win   = cand[k];
            end
        end
    end

endmodule

// File: rtl/pciarb_grant_ctrl.sv
module pciarb_grant_ctrl
    import pciarb_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          bus_idle,
    input  logic          pick_found,
    input  logic [IW-1:0] pick_win,
    output logic [N-1:0]  gnt_vec,
    output logic [IW-1:0] last_idx
);

    typedef struct packed {
        logic          held;
        logic [IW-1:0] owner;
        logic [IW-1:0] last;
    } arb_state_t;

    localparam logic [IW-1:0] LAST_INIT = IW'(N - 1);

    arb_state_t st_q, st_d;
    arb_act_e   act;
    logic [N-1:0] owner_oh;
    logic         own_req;
    logic         rival_req;

    for (genvar i = 0; i < N; i++) begin : g_owner
        assign owner_oh[i] = (st_q.owner == IW'(i));
        assign gnt_vec[i]  = st_q.held & owner_oh[i];
    end

    assign own_req   = |(req & owner_oh);
    assign rival_req = |(req & ~owner_oh);

    always_comb begin
        act = ACT_NONE;
        if (st_q.held) begin
            if (!own_req || rival_req) begin
                act = ACT_DROP;
            end else begin
                act = ACT_HOLD;
            end
        end else if (bus_idle && pick_found) begin
            act = ACT_ISSUE;
        end
    end

    always_comb begin
        st_d = st_q;
        case (act)
            ACT_DROP: begin
                st_d.held = 1'b0;
            end
            ACT_ISSUE: begin
                st_d.held  = 1'b1;
                st_d.owner = pick_win;
                st_d.last  = pick_win;
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.held  <= 1'b0;
            st_q.owner <= '0;
            st_q.last  <= LAST_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign last_idx = st_q.last;

endmodule

// File: rtl/pci_arbiter.sv
module pci_arbiter
    import pciarb_pkg::*;
#(
    parameter int NUM_MASTERS = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_MASTERS-1:0] req_n,
    input  logic                   frame_n,
    input  logic                   irdy_n,
    output logic [NUM_MASTERS-1:0] gnt_n
);

    localparam int IW = idx_width(NUM_MASTERS);

    logic [NUM_MASTERS-1:0] req;
    logic [NUM_MASTERS-1:0] gnt_vec;
    logic                   bus_idle;
    logic                   pick_found;
    logic [IW-1:0]          pick_win;
    logic [IW-1:0]          last_idx;

    assign req   = ~req_n;
    assign gnt_n = ~gnt_vec;

    pciarb_idle_det u_idle (
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .bus_idle (bus_idle)
    );

    pciarb_rr_pick #(.N(NUM_MASTERS), .IW(IW)) u_pick (
        .req   (req),
        .last  (last_idx),
        .found (pick_found),
        .win   (pick_win)
    );

    pciarb_grant_ctrl #(.N(NUM_MASTERS), .IW(IW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .bus_idle   (bus_idle),
        .pick_found (pick_found),
        .pick_win   (pick_win),
        .gnt_vec    (gnt_vec),
        .last_idx   (last_idx)
    );

endmodule

// File: rtl/pciarb_chk.sv
module pciarb_chk #(
    parameter int NUM_MASTERS = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_MASTERS-1:0] req_n,
    input logic                   frame_n,
    input logic                   irdy_n,
    input logic [NUM_MASTERS-1:0] gnt_n
);

    logic rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        // R2
        if (rst_d === 1'b1) begin
            reset_clear_chk: assert (&gnt_n);
        end
    end

    // R1
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~gnt_n));

    // R3
    idle_issue_chk: assert property (@(posedge clk) disable iff (rst)
        ((&gnt_n) && frame_n && irdy_n && !(&req_n)) |=> !(&gnt_n));

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((&gnt_n) && !(frame_n && irdy_n)) |=> (&gnt_n));

    // R6
    gap_move_chk: assert property (@(posedge clk) disable iff (rst)
        !(&gnt_n) |=> ((&gnt_n) || $stable(gnt_n)));

    // R7
    withdraw_chk: assert property (@(posedge clk) disable iff (rst)
        ((~gnt_n & req_n) != '0) |=> (&gnt_n));

    // R8
    rival_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!(&gnt_n) && ((~req_n & gnt_n) != '0)) |=> (&gnt_n));

    // R9
    keep_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (!(&gnt_n) && (~req_n == ~gnt_n)) |=> $stable(gnt_n));

endmodule

bind pci_arbiter pciarb_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (.*);

// File: tb/sim_pci_arbiter.sv
`timescale 1ns/1ps
module sim_pci_arbiter;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req_n = '1;
    logic         frame_n = 1'b1;
    logic         irdy_n = 1'b1;
    logic [N-1:0] gnt_n;

    int checks = 0;
    int failures = 0;

    // reference model state
    int  m_held = 0;
    int  m_owner = 0;
    int  m_last = N - 1;

    always #2 clk = ~clk;

    pci_arbiter #(.NUM_MASTERS(N)) u0 (
        .clk     (clk),
        .rst     (rst),
        .req_n   (req_n),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .gnt_n   (gnt_n)
    );

    function automatic logic [N-1:0] model_gnt();
        logic [N-1:0] v = '1;
        if (m_held != 0) v[m_owner] = 1'b0;
        return v;
    endfunction

    task automatic check_vec(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s gnt_n actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge(input logic [N-1:0] r, input logic f, input logic i);
        if (m_held != 0) begin
            int rivals = 0;
            for (int j = 0; j < N; j++) if (j != m_owner && !r[j]) rivals++;
            if (r[m_owner] || rivals > 0) m_held = 0;
        end else if (f && i) begin
            for (int k = 1; k <= N; k++) begin
                int c = (m_last + k) % N;
                if (!r[c]) begin
                    m_held = 1; m_owner = c; m_last = c;
                    break;
                end
            end
        end
    endtask

    // drive at negedge, model at posedge, compare at next negedge
    task automatic step(input logic [N-1:0] r, input logic f, input logic i);
        req_n = r; frame_n = f; irdy_n = i;
        @(posedge clk);
        model_edge(r, f, i);
        @(negedge clk);
        check_vec(gnt_n, model_gnt(), "R1 R6 model");
        checks++;
        if (!$onehot0(~gnt_n)) begin
            failures++;
            $display("FAIL R1 gnt_n actual=%b expected=at most one low", gnt_n);
        end
    endtask

    task automatic expect_owner(input int who, input string tag);
        logic [N-1:0] e = '1;
        if (who >= 0) e[who] = 1'b0;
        check_vec(gnt_n, e, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_held = 0; m_owner = 0; m_last = N - 1;
        expect_owner(-1, "R2 reset");

        // two masters request together on a quiet bus
        step(4'b1100, 1, 1); expect_owner(0, "R3 R5 first pick");
        step(4'b1100, 1, 1); expect_owner(-1, "R8 rival drop");
        step(4'b1100, 1, 1); expect_owner(1, "R5 second pick");
        step(4'b1101, 1, 1); expect_owner(1, "R9 keep");
        step(4'b1101, 0, 0); expect_owner(1, "R9 keep busy");
        step(4'b1111, 1, 1); expect_owner(-1, "R7 withdraw");

        // grant held back while bus busy
        step(4'b1011, 0, 1); expect_owner(-1, "R4 frame busy");
        step(4'b1011, 1, 0); expect_owner(-1, "R4 irdy busy");
        step(4'b1011, 1, 1); expect_owner(2, "R3 idle grant");

        // every master requesting: full rotation with gaps
        step(4'b0000, 0, 0); expect_owner(-1, "R8 drop while busy");
        step(4'b0000, 1, 1); expect_owner(3, "R5 rotate to 3");
        step(4'b0000, 1, 1); expect_owner(-1, "R6 gap");
        step(4'b0000, 1, 1); expect_owner(0, "R5 wrap to 0");
        step(4'b0000, 1, 1); expect_owner(-1, "R6 gap");
        step(4'b0000, 1, 1); expect_owner(1, "R5 master 1 after three");
        step(4'b1111, 1, 1); expect_owner(-1, "R7 release");

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic [N-1:0] r = N'($urandom);
            logic f = ($urandom % 4) != 0;
            logic i = ($urandom % 4) != 0;
            step(r, f, i);
        end

        // reset in mid-grant
        step(4'b1110, 1, 1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_held = 0; m_owner = 0; m_last = N - 1;
        expect_owner(-1, "R2 mid reset");
        step(4'b0111, 1, 1); expect_owner(3, "R2 R5 pointer after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule